// File: doc/BRIEF.md
# Floating-Point Result Sign Finisher and Class Flag Generator

This block takes a floating-point result and applies the last corrections to its sign. It then packs the result word and records a five-bit class/sign code in a 32-bit status register. Each cycle the arithmetic pipeline presents the following inputs:

- the raw sign and the result class;
- a 64-bit result in double format;
- a flag saying whether the value is really a single-precision result widened to double;
- the effective-subtract and negate-result flags;
- the two-bit rounding mode;
- a default-NaN request;
- an update enable.

In the first cycle the block settles the final sign and registers it, together with the word. In the next cycle that one registered sign drives two things: bit 63 of the packed result, and the class code that is written into status bits 16..12. The packed word and the flag field therefore always agree on the sign.

The sign is corrected in three cases. A zero produced by an effective subtraction takes its sign from the rounding mode. A negated multiply-add result is inverted, except when the result is a NaN. A generated default NaN is always positive. To classify the value, the block reads the exponent and fraction of the packed word. For single-precision results the exponent above which a value counts as normal is raised to 0x380.

Top module: `fp_result_flagger`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it is released, the packed result and the status register read zero.
- R2: When the subtract flag is high, the class is zero (class encoding 00 zero, 01 finite, 10 infinity, 11 NaN) and no default NaN is requested, the sign before negation is rnd[1] AND rnd[0]. The rounding encoding is 00 nearest, 01 toward zero, 10 toward +infinity, 11 toward -infinity, so only mode 11 gives -0. The raw sign is ignored in this case.
- R3: When the negate flag is high, the sign is inverted unless the class is NaN (11) or a default NaN is requested.
- R4: A default-NaN request makes the packed result 0x7FF8000000000000 (sign 0), whatever the other inputs.
- R5: The packed result appears one clock after its inputs. Bits 62..0 are the input word's bits 62..0, and bit 63 is the final sign.
- R6: Class codes in status bits 16..12 are: NaN 0x11, -inf 0x09, +inf 0x05, -normal 0x08, +normal 0x04, -denormal 0x18, +denormal 0x14, -zero 0x12, +zero 0x02. They are derived from the packed word: an exponent of 0x7FF with a nonzero fraction is a NaN, and with a zero fraction it is an infinity. For double results, any other nonzero exponent is normal.
- R7: When the single flag is high, a value is normal only if its exponent exceeds 0x380. Otherwise it is denormal when the exponent or fraction is nonzero, and zero when both are zero.
- R8: When the update enable is high, the code is written into status bits 16..12 two clocks after the inputs. All other status bits keep their value, which is zero.
- R9: When the update enable is low, the status register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rawSign | input | 1 | Sign from the arithmetic path |
| resClass | input | 2 | 00 zero, 01 finite, 10 infinity, 11 NaN |
| resWord | input | 64 | Result in double format (bit 63 ignored) |
| isSingle | input | 1 | Result is single precision held in double format |
| isSubtract | input | 1 | Operation was an effective subtraction |
| negateRes | input | 1 | Result is to be negated |
| rndMode | input | 2 | Rounding mode |
| defNan | input | 1 | Replace the result with the default quiet NaN |
| updEn | input | 1 | Write the class code to the status register |
| packedRes | output | 64 | Packed result, one cycle latency |
| statusReg | output | 32 | Status register, class code in bits 16..12 |

## Verification
A wrong sign decision shows up one clock later as a wrong bit 63 on the packed result. One clock after that, the same error appears as a code with the wrong sign half in the status field. If the classifier compares against the wrong threshold or mishandles the fraction test, the packed word is correct but the status code two clocks after the inputs is wrong. The random stimulus places exponents near 0x380 and near zero to expose this. If the status register updates at the wrong time, it differs from the bench's running model at the first idle cycle.

// File: rtl/fpflag_pkg.sv
package fpflag_pkg;
  localparam int WORD_W = 64;
  localparam int EXP_W = 11;
  localparam int FRAC_W = 52;
  localparam int CODE_W = 5;
  localparam int STAT_W = 32;
  localparam int CODE_LSB = 12;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'b00,
    CLS_FINITE = 2'b01,
    CLS_INF = 2'b10,
    CLS_NAN = 2'b11
  } resClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic signNext;   // corrected sign to register
    logic forceNan;   // substitute default NaN
    logic writeFlags; // status write in this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/fpflag_ctrl.sv
module fpflag_ctrl
  import fpflag_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rawSign,
  input  logic [1:0]  resClass,
  input  logic        isSubtract,
  input  logic        negateRes,
  input  logic [1:0]  rndMode,
  input  logic        defNan,
  input  logic        updEn,
  output ctrlStrobe_t strobe
);
  logic effNan;
  logic zeroSign;
  logic signFixed;
  logic updQ;

  always_comb begin
    effNan = defNan || (resClass == CLS_NAN);
    zeroSign = rndMode[1] & rndMode[0];
    signFixed = defNan ? 1'b0 : rawSign;
    if (!defNan && isSubtract && resClass == CLS_ZERO) signFixed = zeroSign;
    if (negateRes && !effNan) signFixed = ~signFixed;
  end

  always_ff @(posedge clk) begin
    if (rst) updQ <= 1'b0;
    else     updQ <= updEn;
  end

  assign strobe.signNext = signFixed;
  assign strobe.forceNan = defNan;
  assign strobe.writeFlags = updQ;
endmodule

// File: rtl/fpflag_classify.sv
module fpflag_classify
  import fpflag_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  parameter logic [EXP_W-1:0] SP_NORM_MIN = 11'h380
) (
  input  logic [EW+FW:0] word,
  input  logic           isSingle,
  output logic [CODE_W-1:0] code
);
  localparam logic [EW-1:0] EXP_MAX = '1;
  logic [EW-1:0] expField;
  logic [FW-1:0] fracField;
  logic sgn;
  logic [EW-1:0] normLimit;

  always_comb begin
    sgn = word[EW+FW];
    expField = word[EW+FW-1:FW];
    fracField = word[FW-1:0];
    normLimit = isSingle ? SP_NORM_MIN : '0;
    if (expField == EXP_MAX) begin
      if (fracField != '0) code = 5'h11;
      else code = sgn ? 5'h09 : 5'h05;
    end else if (expField > normLimit) begin
      code = sgn ? 5'h08 : 5'h04;
    end else if (expField != '0 || fracField != '0) begin
      code = sgn ? 5'h18 : 5'h14;
    end else begin
      code = sgn ? 5'h12 : 5'h02;
    end
  end
endmodule

// File: rtl/fpflag_dp.sv
module fpflag_dp
  import fpflag_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int SW = STAT_W,
  parameter int CLSB = CODE_LSB
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [W-1:0] resWord,
  input  logic        isSingle,
  input  ctrlStrobe_t strobe,
  output logic [W-1:0] packedRes,
  output logic [SW-1:0] statusReg
);
  localparam int CMSB = CLSB + CODE_W - 1;
  localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic          signQ;
  logic [W-2:0]  magQ;
  logic          singleQ;
  logic          nanQ;
  logic [CODE_W-1:0] codeNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      signQ <= 1'b0;
      magQ <= '0;
      singleQ <= 1'b0;
      nanQ <= 1'b0;
    end else begin
      signQ <= strobe.signNext;
      magQ <= resWord[W-2:0];
      singleQ <= isSingle;
      nanQ <= strobe.forceNan;
    end
  end

  assign packedRes = nanQ ? DEF_NAN : {signQ, magQ};

  fpflag_classify u_cls (
    .word(packedRes),
    .isSingle(singleQ),
    .code(codeNow)
  );

  always_ff @(posedge clk) begin
    if (rst) statusReg <= '0;
    else if (strobe.writeFlags) statusReg[CMSB:CLSB] <= codeNow;
  end
endmodule

// File: rtl/fp_result_flagger.sv
module fp_result_flagger
  import fpflag_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rawSign,
  input  logic [1:0]  resClass,
  input  logic [63:0] resWord,
  input  logic        isSingle,
  input  logic        isSubtract,
  input  logic        negateRes,
  input  logic [1:0]  rndMode,
  input  logic        defNan,
  input  logic        updEn,
  output logic [63:0] packedRes,
  output logic [31:0] statusReg
);
  ctrlStrobe_t strobe;

  fpflag_ctrl u_ctrl (
    .clk(clk), .rst(rst), .rawSign(rawSign), .resClass(resClass),
    .isSubtract(isSubtract), .negateRes(negateRes), .rndMode(rndMode),
    .defNan(defNan), .updEn(updEn), .strobe(strobe)
  );

  fpflag_dp u_dp (
    .clk(clk), .rst(rst), .resWord(resWord), .isSingle(isSingle),
    .strobe(strobe), .packedRes(packedRes), .statusReg(statusReg)
  );
endmodule

// File: rtl/fpflag_chk.sv
module fpflag_chk (
  input logic        clk,
  input logic        rst,
  input logic        rawSign,
  input logic [1:0]  resClass,
  input logic [63:0] resWord,
  input logic        isSingle,
  input logic        isSubtract,
  input logic        negateRes,
  input logic [1:0]  rndMode,
  input logic        defNan,
  input logic        updEn,
  input logic [63:0] packedRes,
  input logic [31:0] statusReg
);
  // R2
  zero_sub_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (isSubtract && resClass == 2'b00 && !negateRes && !defNan)
      |=> packedRes[63] == $past(rndMode[1] & rndMode[0]));
  // R3
  nan_no_negate_chk: assert property (@(posedge clk) disable iff (rst)
    (negateRes && resClass == 2'b11 && !isSubtract && !defNan)
      |=> packedRes[63] == $past(rawSign));
  // R4
  default_nan_chk: assert property (@(posedge clk) disable iff (rst)
    defNan |=> packedRes == 64'h7FF8_0000_0000_0000);
  // R5
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!defNan && !negateRes && !isSubtract)
      |=> packedRes == {$past(rawSign), $past(resWord[62:0])});
  // R8
  other_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    statusReg[31:17] == 15'd0 && statusReg[11:0] == 12'd0);
  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !updEn |=> ##1 $stable(statusReg));
endmodule

bind fp_result_flagger fpflag_chk chk_i (.*);

// File: tb/fp_result_flagger_tb.sv
module fp_result_flagger_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rawSign = 1'b0;
  logic [1:0] resClass = 2'b00;
  logic [63:0] resWord = '0;
  logic isSingle = 1'b0;
  logic isSubtract = 1'b0;
  logic negateRes = 1'b0;
  logic [1:0] rndMode = 2'b00;
  logic defNan = 1'b0;
  logic updEn = 1'b0;
  logic [63:0] packedRes;
  logic [31:0] statusReg;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] statusModel = '0;

  always #5 clk = ~clk;

  fp_result_flagger dut_i (.*);

  function automatic logic expSign(logic s0, logic [1:0] c, logic sub, logic neg,
                                   logic [1:0] rm, logic dn);
    logic s;
    s = dn ? 1'b0 : s0;
    if (!dn && sub && c == 2'b00) s = rm[1] & rm[0];
    if (neg && !dn && c != 2'b11) s = ~s;
    return s;
  endfunction

  function automatic logic [4:0] expCode(logic [63:0] w, logic sp);
    logic [10:0] e;
    logic [51:0] f;
    logic s;
    s = w[63]; e = w[62:52]; f = w[51:0];
    if (e == 11'h7FF) return (f != 0) ? 5'h11 : (s ? 5'h09 : 5'h05);
    if (e > (sp ? 11'h380 : 11'h000)) return s ? 5'h08 : 5'h04;
    if (e != 0 || f != 0) return s ? 5'h18 : 5'h14;
    return s ? 5'h12 : 5'h02;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, check packed one edge later, status one more edge later
  task automatic runOp(logic s, logic [1:0] c, logic [63:0] w, logic sp, logic sub,
                       logic neg, logic [1:0] rm, logic dn, logic up, string tag);
    logic [63:0] expPacked;
    logic [4:0] code;
    rawSign = s; resClass = c; resWord = w; isSingle = sp; isSubtract = sub;
    negateRes = neg; rndMode = rm; defNan = dn; updEn = up;
    expPacked = dn ? 64'h7FF8_0000_0000_0000 : {expSign(s, c, sub, neg, rm, dn), w[62:0]};
    code = expCode(expPacked, sp);
    @(negedge clk);
    check({tag, " packed (R5)"}, packedRes, expPacked);
    updEn = 1'b0; defNan = 1'b0; negateRes = 1'b0; isSubtract = 1'b0;
    if (up) statusModel[16:12] = code;
    @(negedge clk);
    check({tag, " status (R6 R7 R8 R9)"}, {32'd0, statusReg}, {32'd0, statusModel});
  endtask

  function automatic logic [63:0] mkWord(logic [1:0] c, logic sp);
    logic [10:0] e;
    logic [51:0] f;
    f = {$urandom, $urandom};
    f = f[51:0];
    case (c)
      2'b00: return 64'd0;
      2'b10: return {1'b0, 11'h7FF, 52'd0};
      2'b11: begin if (f == 0) f = 52'd1; return {1'b0, 11'h7FF, f}; end
      default: begin
        case ($urandom % 4)
          0: e = 11'h380 - 11'd2 + 11'($urandom % 5);
          1: e = 11'($urandom % 3);
          default: e = 11'($urandom % 11'h7FF);
        endcase
        if (e == 0 && f == 0) f = 52'd5;
        if (sp) f[28:0] = '0;
        if (e == 0 && f == 0) f[40] = 1'b1;
        return {1'b0, e, f};
      end
    endcase
  endfunction

  initial begin
    #1500000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 packed in reset", packedRes, 64'd0);
    check("R1 status in reset", {32'd0, statusReg}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 packed after reset", packedRes, 64'd0);
    check("R1 status after reset", {32'd0, statusReg}, 64'd0);
    // every class, both signs, all rounding modes
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 2; s++)
        for (int rm = 0; rm < 4; rm++) begin
          runOp(s[0], c[1:0], mkWord(c[1:0], 1'b0), 1'b0, 1'b1, 1'b0, rm[1:0], 1'b0, 1'b1, "R2 sweep");
          runOp(s[0], c[1:0], mkWord(c[1:0], 1'b1), 1'b1, 1'b0, 1'b1, rm[1:0], 1'b0, 1'b1, "R3 sweep");
        end
    // single threshold corner cases
    runOp(1'b0, 2'b01, {1'b0, 11'h380, 52'h8_0000_0000_0000}, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, "R7 at 0x380");
    runOp(1'b1, 2'b01, {1'b0, 11'h381, 52'd0}, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, "R7 at 0x381");
    runOp(1'b0, 2'b01, {1'b0, 11'h380, 52'd0}, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, "R6 double 0x380");
    runOp(1'b1, 2'b01, {1'b0, 11'h000, 52'd1}, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, "R6 denormal");
    // default NaN overrides everything, then hold without update
    runOp(1'b1, 2'b01, 64'hC000_0000_0000_0000, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1, "R4 default nan");
    runOp(1'b1, 2'b00, 64'd0, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, "R9 no update");
    runOp(1'b0, 2'b00, 64'd0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, "R3 negated zero-sub");
    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [1:0] c;
      logic sp;
      c = 2'($urandom % 4);
      sp = 1'($urandom % 2);
      runOp(1'($urandom), c, mkWord(c, sp), sp, 1'($urandom), 1'($urandom),
            2'($urandom), ($urandom % 8) == 0, ($urandom % 4) != 0, "random");
    end
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule